// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM of 65,536 one-bit words. The RAM has separate input and output data pins, plus active-low chip-enable and write-enable strobes. The host offers one word at a time on a valid/ready handshake, carrying a 16-bit address, a write flag and a single write bit. The controller drives the RAM pins through a read or write sequence whose length, in clock cycles, comes from the RAM's minimum analog times.

Every minimum time is a parameter in picoseconds, as is the clock period. The wait count for each phase is the time divided by the period and rounded up, with a floor of one cycle. A write keeps both strobes low for the longest of the write-pulse, chip-enable-to-end, address-to-end and data-setup counts. A read keeps chip enable low for the access count, then captures the RAM output and reports it with a one-cycle response strobe. Both strobes return high together, so address and data hold after a write are zero, which the RAM allows.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and for the two synchronising cycles after its release, `mem_ce_n` and `mem_we_n` are 1, `rsp_valid` is 0, `rsp_data`, `mem_addr` and `mem_din` are 0, and `req_ready` is 0; `req_ready` rises once the controller is idle after that.
- R2: Strobe encoding: a read drives `mem_ce_n`=0 with `mem_we_n`=1, and a write drives both to 0. `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R3: A write drives both strobes low in the cycle after acceptance, for exactly WR_CYC cycles (2 with default parameters: 8 ns and 6 ns over a 5 ns clock). `mem_addr` and `mem_din` hold the accepted values throughout, and the RAM then holds the written bit.
- R4: A read drives `mem_ce_n` low in the cycle after acceptance, for exactly RD_CYC cycles (2 with defaults: 10 ns over 5 ns). The output is sampled at the edge that raises `mem_ce_n`, and from that edge `rsp_valid` is 1 for one cycle with `rsp_data` equal to the last bit written to that address (0 if never written). `rsp_data` keeps its value until the next read completes.
- R5: `req_ready` is 0 from the cycle after acceptance until the operation ends. A request presented while `req_ready` is 0 is ignored: it changes neither the pins nor the RAM contents.
- R6: `mem_addr` is loaded only when a request is accepted. It stays constant while `mem_ce_n` is 0, and it ignores later changes of `req_addr`.
- R7: Both strobes stay high for at least one full cycle between two operations. A new request is accepted at the earliest in the cycle after the previous one ends, so one operation occupies RD_CYC+1 or WR_CYC+1 cycles.
- R8: A write never raises `rsp_valid`, and it leaves `rsp_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle strobe: read data is valid |
| rsp_data | output | 1 | Captured read bit |
| mem_addr | output | 16 | RAM address pins |
| mem_din | output | 1 | RAM data-input pin |
| mem_dout | input | 1 | RAM data-output pin |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |

## Verification
The bench's RAM model drives unknown data until 9 ns after each address or strobe change. A controller that sampled one cycle too early would therefore return unknown data. The model also measures the write pulse, the address age and the data age at every rising write edge, so a shortened write pulse or a data change late in the pulse is reported with the measured time. A request pulsed while the controller is busy, and host-side address and data changes right after acceptance, expose a controller that re-latches its inputs mid-operation: the pins would differ from the reference, and the read-back would show a stray write. Back-to-back traffic to a small set of addresses checks the one-cycle gap between operations, and confirms that overwritten and never-written words read back correctly.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctl_state_e;

  // Cycles needed to cover a minimum time: rounded up, never below one.
  function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val - 1'b1;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3 R4: a zero load would wrap the counter and stretch the phase
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             req_ready,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture,
  output logic             ce_n,
  output logic             we_n,
  output logic             rsp_valid
);

  ctl_state_e state_q, state_d;
  logic       ce_q, ce_d, we_q, we_d, rsp_q;
  logic       finish;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign finish   = (state_q != ST_IDLE) && expired;
  assign capture  = (state_q == ST_READ) && expired;
  assign load     = accept;
  assign load_val = req_write ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);

  always_comb begin
    state_d = state_q;
    ce_d    = ce_q;
    we_d    = we_q;
    if (accept) begin
      state_d = req_write ? ST_WRITE : ST_READ;
      ce_d    = 1'b0;
      we_d    = ~req_write;
    end else if (finish) begin
      state_d = ST_IDLE;
      ce_d    = 1'b1;
      we_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      we_q    <= we_d;
      rsp_q   <= capture;
    end
  end

  assign req_ready = (state_q == ST_IDLE) && rst_n;
  assign ce_n      = ce_q;
  assign we_n      = we_q;
  assign rsp_valid = rsp_q;

  a_r2_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> !ce_q);
  a_r5_ready_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_q && we_q));
  a_r4_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |=> !rsp_q);
  a_r4_rsp_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |-> ce_q);
  a_r8_write_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |=> !rsp_q);

endmodule

// File: rtl/sram_ctl_hold.sv
module sram_ctl_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  input  logic          mem_dout,
  output logic [AW-1:0] mem_addr,
  output logic          mem_din,
  output logic          rsp_data
);

  logic [AW-1:0] addr_q;
  logic          din_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      din_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= 1'b0;
    else if (capture) rd_q <= mem_dout;
  end

  assign mem_addr = addr_q;
  assign mem_din  = din_q;
  assign rsp_data = rd_q;

  a_r8_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_q));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CLK_PS   = 5000,
  parameter int T_AA_PS  = 10000,
  parameter int T_WP_PS  = 8000,
  parameter int T_CW_PS  = 8000,
  parameter int T_AW_PS  = 8000,
  parameter int T_DW_PS  = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rsp_valid,
  output logic          rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_din,
  input  logic          mem_dout,
  output logic          mem_ce_n,
  output logic          mem_we_n
);

  localparam int RD_CYC = int'(wait_cycles(T_AA_PS, CLK_PS));
  localparam int WR_CYC = int'(max2(max2(wait_cycles(T_WP_PS, CLK_PS), wait_cycles(T_CW_PS, CLK_PS)),
                                    max2(wait_cycles(T_AW_PS, CLK_PS), wait_cycles(T_DW_PS, CLK_PS))));
  localparam int CNT_W  = $clog2(int'(max2(RD_CYC, WR_CYC)) + 1);

  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic             accept, load, capture, expired;
  logic [CNT_W-1:0] load_val;

  sram_ctl_fsm #(.CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .req_ready(req_ready), .accept(accept), .load(load),
    .load_val(load_val), .capture(capture), .ce_n(mem_ce_n), .we_n(mem_we_n),
    .rsp_valid(rsp_valid));

  sram_ctl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .load_val(load_val), .expired(expired));

  sram_ctl_hold #(.AW(AW)) i_hold (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dout(mem_dout),
    .mem_addr(mem_addr), .mem_din(mem_din), .rsp_data(rsp_data));

  // Checker counters: length of the current low phase of each strobe
  logic [CNT_W:0] we_lo_q, ce_lo_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_lo_q <= '0;
      ce_lo_q <= '0;
    end else begin
      we_lo_q <= mem_we_n ? '0 : ((&we_lo_q) ? we_lo_q : we_lo_q + 1'b1);
      ce_lo_q <= mem_ce_n ? '0 : ((&ce_lo_q) ? ce_lo_q : ce_lo_q + 1'b1);
    end
  end

  a_r3_we_pulse_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> (we_lo_q >= (CNT_W+1)'(WR_CYC)));
  a_r4_access_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (ce_lo_q >= (CNT_W+1)'(RD_CYC)));
  a_r3_din_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_din));
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  a_r7_gap_before_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(mem_ce_n) |-> ($past(mem_we_n) && !req_ready));

endmodule

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

  localparam int RD = 2;  // ceil(10 ns / 5 ns)
  localparam int WR = 2;  // max of ceil(8/5), ceil(6/5)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_data, mem_din, mem_ce_n, mem_we_n;
  logic [15:0] mem_addr;
  logic        mem_dout;

  always #2.5 clk = ~clk;

  sram_ctl i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- RAM model ----------------
  bit ram [int];
  function automatic bit ram_rd(input int a);
    return ram.exists(a) ? ram[a] : 1'b0;
  endfunction

  int  tok = 0;
  real t_wf = 0.0, t_cf = 0.0, t_d = 0.0, t_a = 0.0;
  bit  we_low_seen = 1'b0;

  always @(mem_ce_n or mem_we_n or mem_addr) begin
    tok++;
    mem_dout = 1'bx;
    if (mem_ce_n === 1'b0 && mem_we_n === 1'b1)
      fork
        begin
          automatic int k = tok;
          #9;
          if (k == tok) mem_dout = ram_rd(int'(mem_addr));
        end
      join_none
  end

  always @(negedge mem_we_n) begin t_wf = $realtime; we_low_seen = 1'b1; end
  always @(negedge mem_ce_n) t_cf = $realtime;
  always @(mem_din)  t_d = $realtime;
  always @(mem_addr) t_a = $realtime;

  always @(posedge mem_we_n) begin
    if (we_low_seen) begin
      we_low_seen = 1'b0;
      chk(($realtime - t_wf) >= 8.0, "R3", "we pulse ps", int'(($realtime - t_wf)*1000), 8000);
      chk(($realtime - t_cf) >= 8.0, "R3", "ce to end ps", int'(($realtime - t_cf)*1000), 8000);
      chk(($realtime - t_a)  >= 8.0, "R3", "addr to end ps", int'(($realtime - t_a)*1000), 8000);
      chk(($realtime - t_d)  >= 6.0, "R3", "data setup ps", int'(($realtime - t_d)*1000), 6000);
      ram[int'(mem_addr)] = mem_din;
    end
  end

  // ---------------- cycle reference model ----------------
  bit sb [int];
  function automatic bit sb_rd(input int a);
    return sb.exists(a) ? sb[a] : 1'b0;
  endfunction

  int        rs = 0, m_state = 0, m_left = 0;
  logic      m_ce = 1, m_we = 1, m_rsp = 0, m_rdat = 0, m_din = 0;
  logic [15:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rs = 0; m_state = 0; m_left = 0; m_ce = 1; m_we = 1;
      m_rsp = 0; m_rdat = 0; m_din = 0; m_addr = '0;
    end else if (rs < 2) begin
      rs++;
    end else begin
      m_rsp = 0;
      case (m_state)
        0: if (req_valid) begin
             m_addr = req_addr; m_din = req_wdata; m_ce = 0; m_we = ~req_write;
             m_state = req_write ? 2 : 1;
             m_left = (req_write ? WR : RD) - 1;
           end
        default: if (m_left == 0) begin
             if (m_state == 1) begin m_rdat = sb_rd(int'(m_addr)); m_rsp = 1; end
             else sb[int'(m_addr)] = m_din;
             m_ce = 1; m_we = 1; m_state = 0;
           end else m_left--;
      endcase
    end
  end

  always @(negedge clk) begin
    automatic bit    in_rst = (rs < 2);
    automatic logic  m_ready = (rs == 2) && (m_state == 0);
    chk(req_ready === m_ready, in_rst ? "R1" : "R5", "req_ready", req_ready, m_ready);
    chk(mem_ce_n === m_ce, in_rst ? "R1" : "R2", "mem_ce_n", mem_ce_n, m_ce);
    chk(mem_we_n === m_we, in_rst ? "R1" : "R2", "mem_we_n", mem_we_n, m_we);
    chk(mem_addr === m_addr, in_rst ? "R1" : "R6", "mem_addr", mem_addr, m_addr);
    chk(mem_din === m_din, in_rst ? "R1" : "R3", "mem_din", mem_din, m_din);
    chk(rsp_valid === m_rsp, in_rst ? "R1" : "R4", "rsp_valid", rsp_valid, m_rsp);
    chk(rsp_data === m_rdat, in_rst ? "R1" : "R8", "rsp_data", rsp_data, m_rdat);
  end

  // ---------------- stimulus ----------------
  // R5 R6: after acceptance the host fields change; with poke a busy-time request follows
  task automatic issue(input bit wr, input logic [15:0] a, input bit d, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_addr = ~a; req_wdata = ~d;
    if (poke) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h00ff;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R2 R3: writes at both address extremes, overwrite of a word
        issue(1, 16'h0000, 1, 0);
        issue(1, 16'hffff, 1, 0);
        issue(1, 16'h1234, 0, 0);
        issue(1, 16'h1234, 1, 0);
        issue(1, 16'h8000, 1, 1);   // R5 busy-time write request ignored
        // R4 R8: read-back, unwritten and poked addresses read 0
        issue(0, 16'h0000, 0, 0);
        issue(0, 16'hffff, 0, 0);
        issue(0, 16'h1234, 0, 1);
        issue(0, 16'h8000, 0, 0);
        issue(0, 16'h80ff, 0, 0);
        issue(0, 16'h12cb, 0, 0);
        issue(0, 16'h5555, 0, 0);
        // R7: back-to-back mixed traffic on a small address set
        begin
          automatic logic [15:0] lf = 16'hace1;
          for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[4], {12'h0a5, lf[3:0]}, lf[7], lf[9] & lf[2]);
          end
        end
        repeat (6) @(negedge clk);
      end
      begin
        #(200000 * 5);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule